// File: doc/BRIEF.md
# Interrupt Level Request Arbiter

This block reduces a vector of fifteen external interrupt levels to a single pending trap code for a processor core. The highest-numbered asserted level wins. The block writes that level's trap code into its pending-code register and raises a hard-interrupt request line. A one-cycle change strobe marks every cycle in which the request moves to a different level.

The pending-code register is shared with synchronous traps. The core posts a synchronous trap through a load port, and the trap-entry logic empties the register with a one-cycle clear once the trap has been taken. External arbitration may replace an external request that is still outstanding. It never overwrites a pending synchronous trap. When every level input falls, an outstanding external request is withdrawn.

Trap codes are `CODE_W` bits wide. The external class is the base code 0x10 with the level number placed in the low four bits, so levels 1 to 15 give codes 0x11 to 0x1F. All state updates on the rising clock edge and takes effect in the following cycle.

Top module: `lvl_irq_arb`

## Requirements
- R1: While rst_ni is low, pend_code_o is 0x00, and irq_o and chg_o are 0.
- R2: Only level_i bits 1 to 15 are considered, and bit 0 has no effect. Among the asserted bits, the highest-numbered one, n, is selected, and its code is 0x10 | n.
- R3: A selected level is written to pend_code_o on the next edge only if the current pending code is 0x00 or lies in the external class (code bits [7:4] equal 0x1). This replaces an outstanding external request on the fly.
- R4: When a write under R3 changes pend_code_o, irq_o is 1 and chg_o is 1 for exactly one cycle. When the selected code equals the pending code, chg_o stays 0 and pend_code_o and irq_o are unchanged.
- R5: While a synchronous trap is pending (a nonzero code outside the external class), asserted levels leave pend_code_o unchanged and chg_o at 0.
- R6: When no level in 1 to 15 is asserted and the pending code is in the external class, pend_code_o becomes 0x00 and irq_o becomes 0 on the next edge, with no chg_o pulse.
- R7: When no level is asserted and a synchronous trap is pending, pend_code_o is left unchanged.
- R8: clr_i high at an edge sets pend_code_o to 0x00 and irq_o to 0 for the next cycle. It has priority over every other input.
- R9: sync_vld_i high at an edge, with clr_i low, loads sync_code_i into pend_code_o and drops irq_o. It has priority over level arbitration. sync_code_i must be a nonzero code outside the external class.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| level_i | input | 16 | Asserted interrupt levels; bit n is level n, bit 0 unused |
| sync_vld_i | input | 1 | Load a synchronous trap code |
| sync_code_i | input | 8 | Synchronous trap code to load |
| clr_i | input | 1 | Trap taken; empty the pending code |
| pend_code_o | output | 8 | Current pending trap code (0 = none) |
| irq_o | output | 1 | Hard-interrupt request |
| chg_o | output | 1 | One-cycle strobe on a new external selection |

## Verification
The bench checks that only bit 0 asserted produces no request, since a design that scanned down to index 0 would post code 0x10. It raises a higher level over an outstanding lower request and then holds the same vector for several cycles. A design that ignored the pending code would fail to replace the request, and one that strobed on every write would pulse chg_o repeatedly. It asserts all levels over a pending synchronous trap, then drops every level, so that a design which preempts or withdraws that trap loses the trap code. It also drives clear and load in the same cycle, and a design with the wrong priority keeps the loaded code instead of zero.

// File: rtl/lvl_arb_pkg.sv
package lvl_arb_pkg;
  localparam int unsigned NUM_LVL  = 15;
  localparam int unsigned LVL_W    = $clog2(NUM_LVL + 1);
  localparam int unsigned CODE_W   = 8;
  localparam logic [CODE_W-1:0] EXT_BASE = 8'h10;
endpackage

// File: rtl/lvl_prio_enc.sv
module lvl_prio_enc #(
  parameter int unsigned NUM_LVL = lvl_arb_pkg::NUM_LVL,
  parameter int unsigned LVL_W   = lvl_arb_pkg::LVL_W
) (
  input  logic [NUM_LVL:0]  level_i,
  output logic              any_o,
  output logic [LVL_W-1:0]  idx_o
);
  // bit 0 carries no level
  logic [NUM_LVL:1] hit;

  for (genvar g = 1; g <= NUM_LVL; g++) begin : g_hit
    if (g == NUM_LVL) begin : g_top
      assign hit[g] = level_i[g];
    end else begin : g_low
      assign hit[g] = level_i[g] & ~(|level_i[NUM_LVL:g+1]);
    end
  end

  always_comb begin
    idx_o = '0;
    for (int i = 1; i <= NUM_LVL; i++) begin
      if (hit[i]) idx_o = LVL_W'(i);
    end
  end

  assign any_o = |level_i[NUM_LVL:1];
endmodule

// File: rtl/ext_req_next.sv
module ext_req_next #(
  parameter int unsigned CODE_W = lvl_arb_pkg::CODE_W,
  parameter int unsigned LVL_W  = lvl_arb_pkg::LVL_W,
  parameter logic [CODE_W-1:0] EXT_BASE = lvl_arb_pkg::EXT_BASE
) (
  input  logic [CODE_W-1:0] pend_i,
  input  logic              irq_i,
  input  logic              any_i,
  input  logic [LVL_W-1:0]  idx_i,
  input  logic              clr_i,
  input  logic              sync_vld_i,
  input  logic [CODE_W-1:0] sync_code_i,
  output logic [CODE_W-1:0] pend_d_o,
  output logic              irq_d_o,
  output logic              chg_d_o,
  output logic              ext_cls_o
);
  localparam int unsigned CLS_W = CODE_W - LVL_W;

  logic [CODE_W-1:0] cand;

  assign ext_cls_o = pend_i[CODE_W-1:LVL_W] == EXT_BASE[CODE_W-1:LVL_W];
  assign cand      = {EXT_BASE[CODE_W-1:LVL_W], idx_i};

  always_comb begin
    pend_d_o = pend_i;
    irq_d_o  = irq_i;
    chg_d_o  = 1'b0;
    if (clr_i) begin
      pend_d_o = '0;
      irq_d_o  = 1'b0;
    end else if (sync_vld_i) begin
      pend_d_o = sync_code_i;
      irq_d_o  = 1'b0;
    end else if (any_i && (pend_i == '0 || ext_cls_o)) begin
      if (cand != pend_i) begin
        pend_d_o = cand;
        irq_d_o  = 1'b1;
        chg_d_o  = 1'b1;
      end
    end else if (!any_i && ext_cls_o) begin
      pend_d_o = '0;
      irq_d_o  = 1'b0;
    end
  end

  logic [CLS_W-1:0] unused_cls;
  assign unused_cls = '0;
endmodule

// File: rtl/lvl_irq_arb.sv
module lvl_irq_arb #(
  parameter int unsigned NUM_LVL = lvl_arb_pkg::NUM_LVL,
  parameter int unsigned LVL_W   = lvl_arb_pkg::LVL_W,
  parameter int unsigned CODE_W  = lvl_arb_pkg::CODE_W,
  parameter logic [CODE_W-1:0] EXT_BASE = lvl_arb_pkg::EXT_BASE
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_LVL:0]  level_i,
  input  logic              sync_vld_i,
  input  logic [CODE_W-1:0] sync_code_i,
  input  logic              clr_i,
  output logic [CODE_W-1:0] pend_code_o,
  output logic              irq_o,
  output logic              chg_o
);
  logic              any;
  logic [LVL_W-1:0]  idx;
  logic [CODE_W-1:0] pend_q, pend_d;
  logic              irq_q, irq_d, chg_q, chg_d, ext_cls;

  lvl_prio_enc #(.NUM_LVL(NUM_LVL), .LVL_W(LVL_W)) u_enc (
    .level_i (level_i),
    .any_o   (any),
    .idx_o   (idx)
  );

  ext_req_next #(.CODE_W(CODE_W), .LVL_W(LVL_W), .EXT_BASE(EXT_BASE)) u_nxt (
    .pend_i      (pend_q),
    .irq_i       (irq_q),
    .any_i       (any),
    .idx_i       (idx),
    .clr_i       (clr_i),
    .sync_vld_i  (sync_vld_i),
    .sync_code_i (sync_code_i),
    .pend_d_o    (pend_d),
    .irq_d_o     (irq_d),
    .chg_d_o     (chg_d),
    .ext_cls_o   (ext_cls)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      irq_q  <= 1'b0;
      chg_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      irq_q  <= irq_d;
      chg_q  <= chg_d;
    end
  end

  assign pend_code_o = pend_q;
  assign irq_o       = irq_q;
  assign chg_o       = chg_q;

  // R4
  irq_ext_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q |-> (pend_q[CODE_W-1:LVL_W] == EXT_BASE[CODE_W-1:LVL_W]));
  // R4
  chg_moved_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chg_q |-> (irq_q && pend_q != $past(pend_q)));
  // R5
  sync_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q != '0 && !ext_cls && !clr_i && !sync_vld_i) |=> ($stable(pend_code_o) && !chg_o));
  // R8
  clr_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (pend_code_o == '0 && !irq_o));
  // R6
  withdraw_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ext_cls && !any && !clr_i && !sync_vld_i) |=> (pend_code_o == '0 && !irq_o && !chg_o));
endmodule

// File: tb/sim_lvl_irq_arb.sv
module sim_lvl_irq_arb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] level = '0;
  logic        sync_vld = 1'b0;
  logic [7:0]  sync_code = '0;
  logic        clr = 1'b0;
  logic [7:0]  pend_code;
  logic        irq, chg;

  int n_chk = 0, n_err = 0;
  string tag = "R1";
  int m_pend = 0;
  bit m_irq = 0, m_chg = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lvl_irq_arb u0 (
    .clk_i(clk), .rst_ni(rst_n), .level_i(level), .sync_vld_i(sync_vld),
    .sync_code_i(sync_code), .clr_i(clr), .pend_code_o(pend_code),
    .irq_o(irq), .chg_o(chg)
  );

  // reference model
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pend = 0; m_irq = 0; m_chg = 0;
    end else begin
      int top;
      top = 0;
      for (int i = 1; i < 16; i++) if (level[i]) top = i;
      m_chg = 0;
      if (clr) begin
        m_pend = 0; m_irq = 0;
      end else if (sync_vld) begin
        m_pend = sync_code; m_irq = 0;
      end else if (top != 0 && (m_pend == 0 || m_pend / 16 == 1)) begin
        if (m_pend != 16 + top) begin
          m_pend = 16 + top; m_irq = 1; m_chg = 1;
        end
      end else if (top == 0 && m_pend / 16 == 1) begin
        m_pend = 0; m_irq = 0;
      end
    end
  end

  task automatic cmp(string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cmp("pend_code", pend_code, m_pend);
    cmp("irq", irq, m_irq);
    cmp("chg", chg, m_chg);
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    // R1 reset state
    step(3);
    rst_n = 1'b1;
    step(2);
    // R2 bit 0 ignored
    tag = "R2"; level = 16'h0001; step(3);
    // R2 single level 3
    level = 16'h0008; step(3);
    // R3 replace on the fly with higher, R2 scan from top
    tag = "R3"; level = 16'hA0A8; step(2);
    tag = "R2"; level = 16'h0006; step(2);
    // R4 hold same: no further strobe
    tag = "R4"; level = 16'h0106; step(1); level = 16'h0107; step(4);
    // R6 withdraw
    tag = "R6"; level = 16'h0000; step(3);
    // R9 sync load with levels quiet
    tag = "R9"; sync_code = 8'h2A; sync_vld = 1'b1; step(1); sync_vld = 1'b0; step(1);
    // R5 levels cannot displace
    tag = "R5"; level = 16'hFFFE; step(4);
    // R7 drop levels, sync stays
    tag = "R7"; level = 16'h0000; step(3);
    // R8 clear then re-request
    tag = "R8"; clr = 1'b1; step(1); clr = 1'b0; step(1);
    level = 16'h0400; step(2);
    clr = 1'b1; step(1); clr = 1'b0; step(2);
    // R8 clear beats load
    clr = 1'b1; sync_vld = 1'b1; sync_code = 8'h05; step(1);
    clr = 1'b0; sync_vld = 1'b0; level = 16'h0000; step(2);
    // R9 load overrides outstanding external request
    tag = "R9"; level = 16'h8000; step(2);
    sync_code = 8'h07; sync_vld = 1'b1; step(1); sync_vld = 1'b0; step(3);
    level = 16'h0000; step(2);
    // R1 reset again mid-run
    tag = "R1"; level = 16'h0010; step(2); rst_n = 1'b0; step(2);
    rst_n = 1'b1; level = 16'h0000; step(2);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule